// File: doc/BRIEF.md
# GPIO Input Event Detector with Polarity Control

This block watches a bank of general-purpose input pins and turns a qualified active level on any of them into a sticky status bit and a single combined event line for a system-management or SCI-style interrupt. Each pin is first brought into the clock domain through a synchronizer. The synchronized level can be read back unchanged. A copy of it passes through a per-pin polarity inverter into a width qualifier, which needs the active level to be present on consecutive sampling clocks before it records an event.

Software programs the block through a small word-addressed register port. Six registers are reachable this way: the pin level, which is read-only, and the polarity, pin-mode, direction, write-one-to-clear status and event enable registers. A pin takes part in event detection only when it is in GPIO mode and set as an input. Bit positions with no physical pin behind them are fixed at zero. A full reset restores every register to its default. A separate soft reset, driven by a write to the system reset-control register, restores only the polarity register.

Top module: `gpio_evt_det`

## Requirements
- R1: Reading address 0 returns the synchronized pin levels ANDed with the implemented-pin mask, and the polarity register has no effect on this value.
- R2: With the polarity bit (address 1) at 0, a pin held high sets its status bit. With the polarity bit at 1, a pin held low sets it. The opposite level never sets it.
- R3: A pin at its active level for one sampling clock does not set status. A pin at its active level for two sampling clocks does set it.
- R4: A pin whose direction bit (address 3) is 1, meaning output, never sets its status bit, whatever its polarity setting.
- R5: A pin whose mode bit (address 2) is 0, meaning native function, never sets its status bit. A mode bit of 1 means GPIO.
- R6: Bit positions outside the implemented-pin mask read as zero in every register and never set status.
- R7: After the full reset, the registers read as follows: polarity 0, mode equal to the implemented-pin mask, direction 0, status 0 and enable 0. The event output is low.
- R8: A one-cycle soft reset pulse clears the polarity register and leaves the mode register unchanged.
- R9: Status (address 4) is sticky. Writing 1 to a bit clears it and writing 0 has no effect. A detection in the same cycle as a clear leaves the bit set.
- R10: The event output is high exactly when some status bit is set together with its enable bit (address 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| soft_rst_i | input | 1 | One-cycle soft reset that clears the polarity register |
| pins_i | input | WIDTH | Asynchronous pin inputs |
| addr_i | input | 3 | Register word address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | WIDTH | Register write data |
| rdata_o | output | WIDTH | Register read data, combinational from addr_i |
| evt_o | output | 1 | Combined enabled event |

## Verification
A vector table drives one pin through pulses made from three things: polarity, pulse level and pulse width. Matched and mismatched level-versus-polarity pairs show whether the inversion is applied correctly. One-clock and two-clock pulses show where the qualification threshold lies. Further vectors switch the pin to output or native mode, which separates real gating from detection that merely happened to miss. Directed tests then cover the following:
- reset values;
- readback of the level through an inverted polarity;
- the unimplemented pin positions;
- the soft reset;
- a status clear that lands while the pin is still active.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      SEL_LEVEL = 3'd0,
      SEL_POL   = 3'd1,
      SEL_MODE  = 3'd2,
      SEL_DIR   = 3'd3,
      SEL_STS   = 3'd4,
      SEL_EN    = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_evt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_qual.sv
module gpio_evt_qual #(
   parameter int WIDTH = 32,
   parameter int QUAL  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] pol_i,
   input  logic [WIDTH-1:0] elig_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] sts_o
);
   generate
      if (QUAL < 1) begin : g_bad
         $error("gpio_evt_qual: QUAL must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] act;
   logic [WIDTH-1:0] qualified;
   logic [WIDTH-1:0] sts_q;

   assign act = lvl_i ^ pol_i;

   generate
      if (QUAL == 1) begin : g_direct
         assign qualified = act;
      end else begin : g_hist
         logic [QUAL-2:0][WIDTH-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '0;
            end else begin
               hist_q[0] <= act;
               for (int h = 1; h < QUAL-1; h++) hist_q[h] <= hist_q[h-1];
            end
         end
         always_comb begin
            qualified = act;
            for (int h = 0; h < QUAL-1; h++) qualified = qualified & hist_q[h];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_i) | (qualified & elig_i);
   end

   assign sts_o = sts_q;

   // R9: a set bit that was not cleared stays set
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));

   // R4 / R5: new status bits appear only on eligible pins
   a_r5_gate_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(elig_i)) == '0));

   // R3: a new status bit needs the active level on two consecutive samples
   generate
      if (QUAL == 2) begin : g_chk2
         a_r3_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(act)) == '0));
      end
   endgenerate
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
   import gpio_evt_pkg::*;
#(
   parameter int               WIDTH = 32,
   parameter logic [WIDTH-1:0] IMPL  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [WIDTH-1:0]  wdata_i,
   input  logic [WIDTH-1:0]  lvl_i,
   input  logic [WIDTH-1:0]  sts_i,
   output logic [WIDTH-1:0]  pol_o,
   output logic [WIDTH-1:0]  mode_o,
   output logic [WIDTH-1:0]  dir_o,
   output logic [WIDTH-1:0]  en_o,
   output logic [WIDTH-1:0]  clr_o,
   output logic [WIDTH-1:0]  rdata_o
);
   logic [WIDTH-1:0] pol_q, mode_q, dir_q, en_q, wmask;

   assign wmask = wdata_i & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         mode_q <= IMPL;
         dir_q  <= '0;
         en_q   <= '0;
      end else begin
         if (soft_rst_i)                         pol_q  <= '0;
         else if (wr_i && addr_i == SEL_POL)     pol_q  <= wmask;
         if (wr_i && addr_i == SEL_MODE)         mode_q <= wmask;
         if (wr_i && addr_i == SEL_DIR)          dir_q  <= wmask;
         if (wr_i && addr_i == SEL_EN)           en_q   <= wmask;
      end
   end

   assign clr_o = (wr_i && addr_i == SEL_STS) ? wmask : '0;

   always_comb begin
      unique case (addr_i)
         SEL_LEVEL: rdata_o = lvl_i & IMPL;
         SEL_POL:   rdata_o = pol_q;
         SEL_MODE:  rdata_o = mode_q;
         SEL_DIR:   rdata_o = dir_q;
         SEL_STS:   rdata_o = sts_i;
         SEL_EN:    rdata_o = en_q;
         default:   rdata_o = '0;
      endcase
   end

   assign pol_o  = pol_q;
   assign mode_o = mode_q;
   assign dir_o  = dir_q;
   assign en_o   = en_q;

   // R8: soft reset empties the polarity register on the next edge
   a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> (pol_q == '0));

   // R8: soft reset does not disturb the mode register
   a_r8_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst_i && !wr_i) |=> $stable(mode_q));
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
   import gpio_evt_pkg::*;
#(
   parameter int               WIDTH       = 32,
   parameter logic [WIDTH-1:0] IMPL_MASK   = 32'h0003_00FF,
   parameter int               SYNC_STAGES = 2,
   parameter int               QUAL_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic [WIDTH-1:0]  pins_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [WIDTH-1:0]  wdata_i,
   output logic [WIDTH-1:0]  rdata_o,
   output logic              evt_o
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad
         $error("gpio_evt_det: WIDTH must be 1..32");
      end
   endgenerate

   logic [WIDTH-1:0] lvl, pol, mode, dir, en, clr, sts, elig;

   gpio_evt_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(lvl));

   gpio_evt_regs #(.WIDTH(WIDTH), .IMPL(IMPL_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
      .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
      .lvl_i(lvl), .sts_i(sts),
      .pol_o(pol), .mode_o(mode), .dir_o(dir), .en_o(en),
      .clr_o(clr), .rdata_o(rdata_o));

   assign elig = mode & ~dir & IMPL_MASK;

   gpio_evt_qual #(.WIDTH(WIDTH), .QUAL(QUAL_CYCLES)) u_qual (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .pol_i(pol),
      .elig_i(elig), .clr_i(clr), .sts_o(sts));

   assign evt_o = |(sts & en);

   // R6: unimplemented positions never hold status
   a_r6_unimpl_sts: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts & ~IMPL_MASK) == '0));

   // R4: output pins never gain status
   a_r4_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts & ~$past(sts) & $past(dir)) == '0));
endmodule

// File: tb/gpio_evt_det_bench.sv
module gpio_evt_det_bench;
   import gpio_evt_pkg::*;
   localparam int          W    = 32;
   localparam logic [31:0] MASK = 32'h0003_00FF;
   localparam int          P    = 1;

   logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, wr = 1'b0, evt;
   logic [W-1:0] pins = '0, wdata = '0, rdata;
   logic [ADDR_W-1:0] addr = '0;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   gpio_evt_det u_gpio_evt_det (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .pins_i(pins),
      .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .evt_o(evt));

   // {expect, hold[3:0], level, dir, mode, pol}
   localparam int NV = 11;
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 high active
      {1'b1, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1},  // R2 low active
      {1'b0, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 wrong level
      {1'b0, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 wrong level inverted
      {1'b0, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 one clock
      {1'b1, 4'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 two clocks
      {1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 one clock inverted
      {1'b1, 4'd2, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 two clocks inverted
      {1'b0, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 output
      {1'b0, 4'd3, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 output inverted
      {1'b0, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0}   // R5 native
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [ADDR_W-1:0] a, output logic [W-1:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7 reset defaults
      rreg(SEL_POL, r);  chk("R7 pol", r, '0);
      rreg(SEL_MODE, r); chk("R7 mode", r, MASK);
      rreg(SEL_DIR, r);  chk("R7 dir", r, '0);
      rreg(SEL_STS, r);  chk("R7 sts", r, '0);
      rreg(SEL_EN, r);   chk("R7 en", r, '0);
      chk("R7 evt", {31'd0, evt}, '0);

      wreg(SEL_EN, 32'h1 << P);
      for (int i = 0; i < NV; i++) begin
         logic [8:0] v = VEC[i];
         logic pol = v[0];
         pins[P] = pol;
         wreg(SEL_POL, {31'd0, pol} << P);
         wreg(SEL_MODE, v[1] ? MASK : (MASK & ~(32'h1 << P)));
         wreg(SEL_DIR, {31'd0, v[2]} << P);
         repeat (4) @(negedge clk);
         wreg(SEL_STS, '1);
         pins[P] = v[3];
         repeat (int'(v[7:4])) @(negedge clk);
         pins[P] = pol;
         repeat (6) @(negedge clk);
         rreg(SEL_STS, r);
         chk($sformatf("R2/R3/R4/R5 vector %0d sts", i), (r >> P) & 1, {31'd0, v[8]});
         chk($sformatf("R10 vector %0d evt", i), {31'd0, evt}, {31'd0, v[8]});
      end
      wreg(SEL_MODE, MASK);
      wreg(SEL_DIR, '0);

      // R1 level ignores polarity
      wreg(SEL_POL, '1);
      pins = '1; repeat (3) @(negedge clk);
      rreg(SEL_LEVEL, r); chk("R1 level ones", r, MASK);
      pins = 32'hA5A5_A5A5; repeat (3) @(negedge clk);
      rreg(SEL_LEVEL, r); chk("R1 level pattern", r, 32'hA5A5_A5A5 & MASK);

      // R6 unimplemented bits
      rreg(SEL_POL, r); chk("R6 pol masked", r, MASK);
      wreg(SEL_DIR, '1); rreg(SEL_DIR, r); chk("R6 dir masked", r, MASK);
      wreg(SEL_DIR, '0);
      wreg(SEL_POL, '0); wreg(SEL_MODE, '1);
      pins = 32'h0000_0100; repeat (6) @(negedge clk);
      rreg(SEL_STS, r); chk("R6 sts unimpl", r & ~MASK, '0);

      // R8 soft reset
      wreg(SEL_POL, 32'h0000_00F0);
      @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      rreg(SEL_POL, r);  chk("R8 pol cleared", r, '0);
      rreg(SEL_MODE, r); chk("R8 mode kept", r, MASK);

      // R9 sticky, W1C and clear collision
      pins = '0; repeat (4) @(negedge clk);
      wreg(SEL_STS, '1);
      pins[P] = 1'b1; repeat (6) @(negedge clk);
      wreg(SEL_STS, '0);
      rreg(SEL_STS, r); chk("R9 write zero keeps", (r >> P) & 1, 1);
      wreg(SEL_STS, 32'h1 << P);
      rreg(SEL_STS, r); chk("R9 collision keeps", (r >> P) & 1, 1);
      pins[P] = 1'b0; repeat (4) @(negedge clk);
      chk("R10 evt enabled", {31'd0, evt}, 1);
      wreg(SEL_STS, 32'h1 << P);
      rreg(SEL_STS, r); chk("R9 clear", (r >> P) & 1, 0);
      chk("R10 evt cleared", {31'd0, evt}, 0);

      // R10 enable gating
      pins[P] = 1'b1; repeat (6) @(negedge clk); pins[P] = 1'b0;
      wreg(SEL_EN, '0); #1;
      chk("R10 evt disabled", {31'd0, evt}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule